// File: doc/BRIEF.md
# FPGA Configuration Stream Controller

This block loads a configuration image into one or more target FPGAs. A host reaches it through a simple 32-bit register interface. The host clears the block, stores the image length in bytes, and sets the enable bit. It then writes the image as 32-bit words to a single data address. Those writes come either from software directly or from a DMA engine that the block paces with a request line. The words pass through a word FIFO and a serializer. The serializer presents the image one byte per configuration clock strobe, taking the most significant byte of each word first.

A level interrupt marks the end of a load. Three events raise it: the target reports configuration-done, a fault is recorded, or the byte count reaches the total and done stays low for too long. The interrupt and all fault flags stay set until the host writes control with the enable bit cleared. That same write also empties the FIFO and zeroes the sent-byte counter. A control bit drives the target's configuration reset line. Setting that bit and then clearing it returns the target to its unconfigured state.

Top module: `cfg_stream_ctrl`

## Requirements
- R1: After reset, control, status, FIFO used, total count and current count read 0, and the interrupt, DMA request and byte strobe outputs are low.
- R2: The FIFO size register at 0x48 reads FIFO_DEPTH*4. The FIFO used register at 0x4C reads 4 times the number of words held, and 0 when the FIFO is empty.
- R3: Words written to 0x3000 leave on the byte output with bits 31:24 first and one byte per strobe cycle. The current count at 0x54 goes up by one for each strobe.
- R4: Streaming stops once the current count equals the total count written at 0x50. Words left in the FIFO are not sent.
- R5: While enabled, target done raises the interrupt and sets status bit 18. The interrupt holds until control at 0x40 is written with bit 0 clear. That write drops the interrupt and clears status bits 3:1.
- R6: A data write to a full FIFO is dropped. It sets status bit 1 and raises the interrupt.
- R7: If the target status input goes low while enabled with the reset bit clear, status bit 2 is set, the interrupt is raised and no further bytes are strobed.
- R8: After the current count reaches the total, if target done stays low for DONE_WAIT cycles, status bit 3 is set and the interrupt is raised.
- R9: With control bits 0 and 2 set, the DMA request is high only when at least half the FIFO is free and fewer bytes have been accepted than the total. In CPU mode (bit 2 clear) it never asserts.
- R10: The configuration reset output follows control bit 1. Writing 3 and then 0 to control clears the target's done indication (status bit 18 reads 0).
- R11: Bytes are strobed only while control bit 0 is set, bit 1 is clear and no interrupt is pending. Writing control with bit 0 set does not flush the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 14 | Register byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| irqOut | output | 1 | Level interrupt: load ended or fault |
| dmaReq | output | 1 | Request for a burst of FIFO_DEPTH/2 words |
| tgtCfgRst | output | 1 | Target configuration reset |
| tgtData | output | 8 | Configuration byte |
| tgtStrobe | output | 1 | High for one cycle per valid byte |
| tgtStatus | input | 1 | Target status, low means the target aborted |
| tgtDone | input | 1 | Target configuration-done |

## Verification
Some properties are checked on every cycle. The interrupt holds until a disabling control write and always drops after one. The FIFO count never exceeds the depth. A write to a full FIFO always sets the overflow flag. Each strobe advances the current count by one without passing the total, and follows a cycle in which streaming was allowed. The DMA request appears only in DMA mode with half the FIFO free. Other behaviour shows only in the bench scenarios, which compare every byte against the image: the byte order, the stop at the total, the timeout delay, the freeze after a lost status, the burst count of a DMA load, and the effect of the reset pulse on the target.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;
  localparam logic [13:0] CTRL_OFS  = 14'h0040;
  localparam logic [13:0] STAT_OFS  = 14'h0044;
  localparam logic [13:0] SIZE_OFS  = 14'h0048;
  localparam logic [13:0] USED_OFS  = 14'h004C;
  localparam logic [13:0] TOTAL_OFS = 14'h0050;
  localparam logic [13:0] CUR_OFS   = 14'h0054;
  localparam logic [13:0] DATA_OFS  = 14'h3000;

  // strobes from control to datapath
  typedef struct packed {
    logic flush;
    logic run;
    logic dmaOk;
    logic loadTotal;
    logic push;
  } dpCmd_t;

  // events from datapath to control
  typedef struct packed {
    logic overflow;
    logic allSent;
  } dpStat_t;
endpackage

// File: rtl/cfg_stream_ctl.sv
module cfg_stream_ctl
  import cfg_stream_pkg::*;
#(
  parameter int DONE_WAIT = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic [13:0] busAddr,
  input  logic [2:0]  ctlWrBits,
  input  logic        tgtStatus,
  input  logic        tgtDone,
  input  dpStat_t     stat,
  output dpCmd_t      cmd,
  output logic [2:0]  ctrlBits,
  output logic [2:0]  errBits,
  output logic        busy,
  output logic        irqOut
);
  localparam int WW = $clog2(DONE_WAIT + 1);

  logic [WW-1:0] waitCnt;
  logic wrCtrl, active, lostNow, doneNow, tmoNow, waiting;

  assign wrCtrl  = busWrEn && (busAddr == CTRL_OFS);
  assign active  = ctrlBits[0] && !ctrlBits[1] && !irqOut;
  assign lostNow = active && !tgtStatus;
  assign doneNow = active && tgtDone;
  assign waiting = active && stat.allSent && !tgtDone;
  assign tmoNow  = waiting && (waitCnt == WW'(DONE_WAIT - 1));
  assign busy    = active;

  always_comb begin
    cmd.flush     = wrCtrl && !ctlWrBits[0];
    cmd.run       = active;
    cmd.dmaOk     = active && ctrlBits[2];
    cmd.loadTotal = busWrEn && (busAddr == TOTAL_OFS);
    cmd.push      = busWrEn && (busAddr == DATA_OFS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlBits <= '0;
      errBits  <= '0;
      irqOut   <= 1'b0;
      waitCnt  <= '0;
    end else if (wrCtrl) begin
      ctrlBits <= ctlWrBits;
      waitCnt  <= '0;
      if (!ctlWrBits[0]) begin
        errBits <= '0;
        irqOut  <= 1'b0;
      end
    end else begin
      if (stat.overflow) begin
        errBits[0] <= 1'b1;
        irqOut     <= 1'b1;
      end
      if (lostNow) begin
        errBits[1] <= 1'b1;
        irqOut     <= 1'b1;
      end
      if (tmoNow) begin
        errBits[2] <= 1'b1;
        irqOut     <= 1'b1;
      end
      if (doneNow) irqOut <= 1'b1;
      if (waiting && !tmoNow) waitCnt <= waitCnt + 1'b1;
      else                    waitCnt <= '0;
    end
  end
endmodule

// File: rtl/cfg_stream_dp.sv
module cfg_stream_dp
  import cfg_stream_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int HALF  = DEPTH / 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpCmd_t      cmd,
  input  logic [31:0] wrData,
  output dpStat_t     stat,
  output logic [7:0]  tgtData,
  output logic        tgtStrobe,
  output logic        dmaReq,
  output logic [AW:0] fifoCnt,
  output logic [31:0] curCnt,
  output logic [31:0] totalCnt
);
  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [31:0]   shWord;
  logic [2:0]    shLeft;
  logic          full, empty, doPush, doPop;
  logic [31:0]   accepted;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full          = (fifoCnt == (AW+1)'(DEPTH));
  assign empty         = (fifoCnt == '0);
  assign doPush        = cmd.push && !full;
  assign stat.overflow = cmd.push && full;
  assign stat.allSent  = (curCnt == totalCnt);
  assign doPop         = cmd.run && (shLeft == 3'd0) && !empty && !stat.allSent;

  // bytes already in the pipe: sent, in the serializer, or queued
  assign accepted = curCnt + 32'(shLeft) + 32'({fifoCnt, 2'b00});
  assign dmaReq   = cmd.dmaOk
                 && (((AW+1)'(DEPTH) - fifoCnt) >= (AW+1)'(HALF))
                 && (accepted < totalCnt);

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCnt   <= '0;
      shWord    <= '0;
      shLeft    <= '0;
      curCnt    <= '0;
      totalCnt  <= '0;
      tgtData   <= '0;
      tgtStrobe <= 1'b0;
    end else if (cmd.flush) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCnt   <= '0;
      shLeft    <= '0;
      curCnt    <= '0;
      tgtStrobe <= 1'b0;
    end else begin
      if (cmd.loadTotal) totalCnt <= wrData;
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      fifoCnt   <= fifoCnt + (AW+1)'(doPush) - (AW+1)'(doPop);
      tgtStrobe <= 1'b0;
      if (doPop) begin
        shWord <= mem[rdPtr];
        shLeft <= 3'd4;
      end else if (cmd.run && shLeft != 3'd0) begin
        tgtData   <= shWord[31:24];
        shWord    <= {shWord[23:0], 8'h00};
        shLeft    <= shLeft - 3'd1;
        tgtStrobe <= 1'b1;
        curCnt    <= curCnt + 32'd1;
      end
    end
  end
endmodule

// File: rtl/cfg_stream_ctrl.sv
module cfg_stream_ctrl
  import cfg_stream_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DONE_WAIT  = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic [13:0] busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  output logic        irqOut,
  output logic        dmaReq,
  output logic        tgtCfgRst,
  output logic [7:0]  tgtData,
  output logic        tgtStrobe,
  input  logic        tgtStatus,
  input  logic        tgtDone
);
  localparam int AW   = $clog2(FIFO_DEPTH);
  localparam int HALF = FIFO_DEPTH / 2;

  dpCmd_t      cmd;
  dpStat_t     stat;
  logic [2:0]  ctrlBits, errBits;
  logic        busy;
  logic [AW:0] fifoCnt;
  logic [31:0] curCnt, totalCnt;

  cfg_stream_ctl #(.DONE_WAIT(DONE_WAIT)) ctl_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .ctlWrBits(busWrData[2:0]), .tgtStatus(tgtStatus), .tgtDone(tgtDone),
    .stat(stat), .cmd(cmd), .ctrlBits(ctrlBits), .errBits(errBits),
    .busy(busy), .irqOut(irqOut)
  );

  cfg_stream_dp #(.DEPTH(FIFO_DEPTH), .HALF(HALF)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(busWrData), .stat(stat),
    .tgtData(tgtData), .tgtStrobe(tgtStrobe), .dmaReq(dmaReq),
    .fifoCnt(fifoCnt), .curCnt(curCnt), .totalCnt(totalCnt)
  );

  assign tgtCfgRst = ctrlBits[1];

  always_comb begin
    case (busAddr)
      CTRL_OFS:  busRdData = {29'b0, ctrlBits};
      STAT_OFS:  busRdData = {13'b0, tgtDone, 2'b0, 12'b0, errBits, busy};
      SIZE_OFS:  busRdData = 32'(FIFO_DEPTH * 4);
      USED_OFS:  busRdData = 32'({fifoCnt, 2'b00});
      TOTAL_OFS: busRdData = totalCnt;
      CUR_OFS:   busRdData = curCnt;
      default:   busRdData = 32'h0;
    endcase
  end
endmodule

// File: rtl/cfg_stream_chk.sv
module cfg_stream_chk
  import cfg_stream_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rstN,
  input logic        busWrEn,
  input logic [13:0] busAddr,
  input logic        ctlWrBit0,
  input logic        irqOut,
  input logic        dmaReq,
  input logic        tgtStrobe,
  input logic [2:0]  ctrlBits,
  input logic [2:0]  errBits,
  input logic [AW:0] fifoCnt,
  input logic [31:0] curCnt,
  input logic [31:0] totalCnt,
  input logic        runOk
);
  logic stopWr;
  assign stopWr = busWrEn && (busAddr == CTRL_OFS) && !ctlWrBit0;

  a_r5_irq_hold: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !stopWr) |=> irqOut);

  a_r5_irq_clear: assert property (@(posedge clk) disable iff (!rstN)
    stopWr |=> (!irqOut && errBits == 3'b000));

  a_r6_overflow_flag: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == DATA_OFS && fifoCnt == (AW+1)'(DEPTH)) |=> (errBits[0] && irqOut));

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    fifoCnt <= (AW+1)'(DEPTH));

  a_r4_no_excess: assert property (@(posedge clk) disable iff (!rstN)
    tgtStrobe |-> (curCnt <= totalCnt));

  a_r3_count_step: assert property (@(posedge clk) disable iff (!rstN)
    tgtStrobe |-> (curCnt == $past(curCnt) + 32'd1));

  a_r11_run_gate: assert property (@(posedge clk) disable iff (!rstN)
    tgtStrobe |-> $past(runOk));

  a_r9_dma_gate: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> (ctrlBits[2] && ctrlBits[0] && !ctrlBits[1] && fifoCnt <= (AW+1)'(DEPTH / 2)));
endmodule

bind cfg_stream_ctrl cfg_stream_chk #(.DEPTH(FIFO_DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .ctlWrBit0(busWrData[0]), .irqOut(irqOut), .dmaReq(dmaReq),
  .tgtStrobe(tgtStrobe), .ctrlBits(ctrlBits), .errBits(errBits),
  .fifoCnt(fifoCnt), .curCnt(curCnt), .totalCnt(totalCnt), .runOk(cmd.run)
);

// File: tb/cfg_stream_ctrl_tb_top.sv
module cfg_stream_ctrl_tb_top;
  localparam int DEPTH = 16;
  localparam int HALF  = DEPTH / 2;
  localparam logic [13:0] A_CTRL = 14'h0040, A_STAT = 14'h0044, A_SIZE = 14'h0048,
                          A_USED = 14'h004C, A_TOT  = 14'h0050, A_CUR  = 14'h0054,
                          A_DATA = 14'h3000;

  // reset readback table: {address, expected value}
  localparam logic [45:0] RST_VEC [6] = '{
    {14'h0040, 32'h0}, {14'h0044, 32'h0}, {14'h0048, 32'd64},
    {14'h004C, 32'h0}, {14'h0050, 32'h0}, {14'h0054, 32'h0}
  };

  logic clk = 0, rstN = 0;
  logic busWrEn = 0;
  logic [13:0] busAddr = '0;
  logic [31:0] busWrData = '0, busRdData;
  logic irqOut, dmaReq, tgtCfgRst, tgtStrobe;
  logic [7:0] tgtData;
  logic tgtStatus = 1;
  logic tgtDone = 0;

  int checks = 0, fails = 0;
  int rxCnt = 0, byteErr = 0, tgtNeed = 1000;
  logic dmaSeen = 0;

  always #10 clk = ~clk;

  cfg_stream_ctrl #(.FIFO_DEPTH(DEPTH), .DONE_WAIT(32)) dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut),
    .dmaReq(dmaReq), .tgtCfgRst(tgtCfgRst), .tgtData(tgtData),
    .tgtStrobe(tgtStrobe), .tgtStatus(tgtStatus), .tgtDone(tgtDone)
  );

  // target model: expects byte n of the image to equal n+0x30
  always @(posedge clk) begin
    if (tgtCfgRst) begin
      rxCnt   <= 0;
      tgtDone <= 0;
    end else if (tgtStrobe) begin
      if (tgtData !== 8'(rxCnt + 48)) byteErr <= byteErr + 1;
      rxCnt <= rxCnt + 1;
      if (rxCnt + 1 == tgtNeed) tgtDone <= 1;
    end
    if (dmaReq) dmaSeen <= 1;
  end

  function automatic logic [31:0] imgWord(input int i);
    return {8'(4*i + 48), 8'(4*i + 49), 8'(4*i + 50), 8'(4*i + 51)};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1; busAddr = a; busWrData = d;
    @(posedge clk);
    #1 busWrEn = 0;
  endtask

  task automatic busRead(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic cfgPulse();
    busWrite(A_CTRL, 32'd3);
    busWrite(A_CTRL, 32'd0);
  endtask

  task automatic waitIrq(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irqOut) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int snap, bursts, wi;
    repeat (4) @(posedge clk);
    #1 rstN = 1;

    // R1 / R2 reset readback from the table
    for (int i = 0; i < 6; i++) begin
      busRead(RST_VEC[i][45:32], rd);
      check(rd == RST_VEC[i][31:0], (i == 2) ? "R2 size register" : "R1 reset register", rd, RST_VEC[i][31:0]);
    end
    check(!irqOut && !dmaReq && !tgtStrobe, "R1 outputs low", {irqOut, dmaReq, tgtStrobe}, 0);

    // CPU-paced load of 8 words
    cfgPulse();
    busWrite(A_TOT, 32'd32);
    tgtNeed = 32;
    busWrite(A_CTRL, 32'd1);
    for (int i = 0; i < 8; i++) busWrite(A_DATA, imgWord(i));
    waitIrq(400);
    check(rxCnt == 32, "R3 bytes received", rxCnt, 32);
    check(byteErr == 0, "R3 byte order", byteErr, 0);
    busRead(A_CUR, rd);
    check(rd == 32, "R3 current count", rd, 32);
    busRead(A_STAT, rd);
    check(rd == 32'h40000, "R5 done status", rd, 32'h40000);
    check(irqOut == 1, "R5 irq on done", irqOut, 1);
    check(dmaSeen == 0, "R9 no request in CPU mode", dmaSeen, 0);
    repeat (20) @(posedge clk);
    #1 check(irqOut == 1, "R5 irq held", irqOut, 1);
    busWrite(A_CTRL, 32'd0);
    check(irqOut == 0, "R5 irq cleared", irqOut, 1'b0);
    busRead(A_USED, rd);
    check(rd == 0, "R2 used empty", rd, 0);

    // R10 reset pulse
    busWrite(A_CTRL, 32'd3);
    @(negedge clk);
    check(tgtCfgRst == 1, "R10 reset line high", tgtCfgRst, 1);
    busWrite(A_CTRL, 32'd0);
    check(tgtCfgRst == 0, "R10 reset line low", tgtCfgRst, 0);
    busRead(A_STAT, rd);
    check(rd == 0, "R10 done cleared", rd, 0);

    // R4 stop at total, R8 timeout
    cfgPulse();
    busWrite(A_TOT, 32'd8);
    tgtNeed = 1000;
    busWrite(A_CTRL, 32'd1);
    for (int i = 0; i < 4; i++) busWrite(A_DATA, imgWord(i));
    repeat (20) @(posedge clk);
    check(rxCnt == 8, "R4 bytes stop at total", rxCnt, 8);
    busRead(A_CUR, rd);
    check(rd == 8, "R4 current count", rd, 8);
    busRead(A_USED, rd);
    check(rd == 8, "R2 used two words", rd, 8);
    busRead(A_STAT, rd);
    check(rd[3] == 0, "R8 no early timeout", rd, 0);
    repeat (60) @(posedge clk);
    busRead(A_STAT, rd);
    check(rd[3] == 1, "R8 timeout flag", rd, 32'h8);
    check(irqOut == 1, "R8 timeout irq", irqOut, 1);
    busWrite(A_CTRL, 32'd0);

    // R6 overflow
    for (int i = 0; i < DEPTH + 1; i++) busWrite(A_DATA, imgWord(i));
    busRead(A_USED, rd);
    check(rd == 64, "R6 used full", rd, 64);
    busRead(A_STAT, rd);
    check(rd == 32'h2, "R6 overflow flag", rd, 32'h2);
    check(irqOut == 1, "R6 overflow irq", irqOut, 1);
    busWrite(A_CTRL, 32'd0);
    busRead(A_USED, rd);
    check(rd == 0, "R2 flushed", rd, 0);

    // R7 lost target status
    cfgPulse();
    busWrite(A_TOT, 32'd64);
    tgtNeed = 64;
    busWrite(A_CTRL, 32'd1);
    for (int i = 0; i < 16; i++) busWrite(A_DATA, imgWord(i));
    @(negedge clk);
    tgtStatus = 0;
    repeat (3) @(posedge clk);
    busRead(A_STAT, rd);
    check(rd[2] == 1, "R7 lost flag", rd, 32'h4);
    check(irqOut == 1, "R7 irq", irqOut, 1);
    snap = rxCnt;
    repeat (20) @(posedge clk);
    check(rxCnt == snap, "R7 streaming stopped", rxCnt, snap);
    check(rxCnt < 64, "R7 load cut short", rxCnt, 64);
    tgtStatus = 1;
    busWrite(A_CTRL, 32'd0);

    // R11 no streaming while disabled, enable keeps FIFO
    cfgPulse();
    busWrite(A_TOT, 32'd8);
    tgtNeed = 1000;
    busWrite(A_DATA, imgWord(0));
    busWrite(A_DATA, imgWord(1));
    repeat (30) @(posedge clk);
    check(rxCnt == 0, "R11 idle when disabled", rxCnt, 0);
    busRead(A_USED, rd);
    check(rd == 8, "R11 words kept", rd, 8);
    busWrite(A_CTRL, 32'd1);
    repeat (30) @(posedge clk);
    check(rxCnt == 8, "R11 sent after enable", rxCnt, 8);
    busWrite(A_CTRL, 32'd0);

    // R9 DMA-paced load
    cfgPulse();
    busWrite(A_TOT, 32'd64);
    tgtNeed = 64;
    busWrite(A_CTRL, 32'd5);
    bursts = 0;
    wi = 0;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      if (irqOut) break;
      if (dmaReq) begin
        bursts++;
        for (int k = 0; k < HALF; k++) begin
          busWrite(A_DATA, imgWord(wi));
          wi++;
        end
      end
    end
    check(bursts == 2, "R9 burst count", bursts, 2);
    check(rxCnt == 64, "R9 bytes received", rxCnt, 64);
    check(byteErr == 0, "R9 byte order", byteErr, 0);
    busRead(A_STAT, rd);
    check(rd == 32'h40000, "R9 done status", rd, 32'h40000);
    busWrite(A_CTRL, 32'd0);
    check(dmaReq == 0, "R9 request off", dmaReq, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule